// File: doc/BRIEF.md
# Little-Endian Unaligned Byte-Addressed Memory Port

The block is a small byte array behind a single request port. One request can be a load or a store of one, two or four bytes. The request may start at any byte address inside the array, with no alignment rule. A multi-byte value is stored with its least significant byte at the starting address. Each higher byte of the value goes to the next higher address. A load gathers the same consecutive bytes and returns them zero-extended to 32 bits.

Every request gets exactly one response, one clock cycle later. A request fails if its size code is reserved or if its last byte would fall past the top of the array. A failed request raises an error flag and returns zero data. It leaves the array untouched. The array size is a parameter.

Top module: `lemp_mem_port`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise. `rsp_rdata` and `rsp_err` belong to that response.
- R2: Ordering is little-endian. The byte at the request address carries value bits 7:0. Address+1 carries bits 15:8, address+2 carries bits 23:16, and address+3 carries bits 31:24. Stores and loads both follow this ordering.
- R3: `req_size` encodes the access width: 2'b00 is one byte, 2'b01 is two bytes, 2'b10 is four bytes. The code 2'b11 is rejected with `rsp_err` high and no write.
- R4: Accesses may start at any byte address, odd or even. Unaligned accesses return the same bytes an aligned access to those addresses would.
- R5: A one-byte load returns zeros in bits 31:8. A two-byte load returns zeros in bits 31:16.
- R6: A store changes only the bytes it covers. The bytes next to it keep their old values.
- R7: If address + width − 1 ≥ DEPTH, the response has `rsp_err` high and `rsp_rdata` zero, and no byte is written.
- R8: A store, accepted or rejected, responds with `rsp_rdata` equal to zero.
- R9: While `rst_n` is low, `rsp_valid`, `rsp_err` and `rsp_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Width code: 00 byte, 01 two bytes, 10 four bytes, 11 reserved |
| req_addr | input | $clog2(DEPTH) | Starting byte address |
| req_wdata | input | 32 | Store value, least significant bits used for narrow stores |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_err | output | 1 | Request rejected (range or reserved size) |
| rsp_rdata | output | 32 | Zero-extended load data, zero for stores and errors |

## Verification
The bench first fills the array with four-byte stores. It then loads a set of known byte patterns at even and odd addresses. A reversed byte order fails these loads, and so does a lane shifted by one. Single-byte stores are followed by wider loads across their neighbours, which shows whether a write spilled into adjacent bytes. Accesses placed exactly at the top of the array, one byte short and one byte over, pin down the range limit. Reserved size codes are also tried, followed by reads of the protected bytes. A long random mix of sizes, addresses and directions then compares every response with a byte-level model.

// File: rtl/lemp_pkg.sv
package lemp_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_QUAD  = 2'b10,
    SZ_RSVD  = 2'b11
  } size_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      SZ_QUAD: size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/lemp_lane_map.sv
module lemp_lane_map import lemp_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0]            addr,
  input  logic [1:0]               size,
  output logic [LANES-1:0][AW-1:0] lane_addr,
  output logic [LANES-1:0]         lane_en,
  output logic                     range_err
);
  localparam int EW = AW + 3;

  logic [2:0]    nbytes;
  logic [EW-1:0] end_excl;

  always_comb begin
    nbytes    = size_bytes(size);
    end_excl  = EW'(addr) + EW'(nbytes);
    range_err = (nbytes == 3'd0) || (end_excl > EW'(DEPTH));
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [EW-1:0] full_addr;
    always_comb begin
      full_addr    = EW'(addr) + EW'(i);
      lane_en[i]   = !range_err && (EW'(i) < EW'(nbytes));
      lane_addr[i] = (full_addr < EW'(DEPTH)) ? full_addr[AW-1:0] : '0;
    end
  end
endmodule

// File: rtl/lemp_byte_store.sv
module lemp_byte_store import lemp_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [LANES-1:0]         lane_en,
  input  logic [LANES-1:0][AW-1:0] lane_addr,
  input  logic [LANES-1:0][7:0]    wbytes,
  output logic [LANES-1:0][7:0]    rbytes
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_en[i]) mem[lane_addr[i]] <= wbytes[i];
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_rd
    assign rbytes[i] = mem[lane_addr[i]];
  end
endmodule

// File: rtl/lemp_read_pack.sv
module lemp_read_pack import lemp_pkg::*; (
  input  logic [LANES-1:0]      lane_en,
  input  logic [LANES-1:0][7:0] rbytes,
  output logic [31:0]           value
);
  for (genvar i = 0; i < LANES; i++) begin : g_pack
    assign value[8*i +: 8] = lane_en[i] ? rbytes[i] : 8'h00;
  end
endmodule

// File: rtl/lemp_mem_port.sv
module lemp_mem_port import lemp_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [31:0]   rsp_rdata
);
  logic [LANES-1:0][AW-1:0] lane_addr;
  logic [LANES-1:0]         lane_en;
  logic                     range_err;
  logic [LANES-1:0][7:0]    wbytes;
  logic [LANES-1:0][7:0]    rbytes;
  logic [31:0]              load_val;
  logic                     store_en;

  logic        valid_d, err_d;
  logic [31:0] rdata_d;

  lemp_lane_map #(.DEPTH(DEPTH), .AW(AW)) u_map (
    .addr(req_addr), .size(req_size),
    .lane_addr(lane_addr), .lane_en(lane_en), .range_err(range_err)
  );

  assign wbytes   = req_wdata;
  assign store_en = req_valid && req_write && !range_err;

  lemp_byte_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(store_en), .lane_en(lane_en),
    .lane_addr(lane_addr), .wbytes(wbytes), .rbytes(rbytes)
  );

  lemp_read_pack u_pack (.lane_en(lane_en), .rbytes(rbytes), .value(load_val));

  always_comb begin
    valid_d = req_valid;
    err_d   = req_valid && range_err;
    rdata_d = (req_valid && !req_write && !range_err) ? load_val : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= valid_d;
      if (req_valid) begin
        rsp_err   <= err_d;
        rsp_rdata <= rdata_d;
      end
    end
  end
endmodule

// File: rtl/lemp_checker.sv
module lemp_checker #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [1:0]    req_size,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [31:0]   rsp_rdata
);
  int unsigned width_c;
  logic        beyond_c;
  always_comb begin
    width_c  = (req_size == 2'b00) ? 1 : (req_size == 2'b01) ? 2 : (req_size == 2'b10) ? 4 : 0;
    beyond_c = (width_c == 0) || ((int'(req_addr) + int'(width_c) - 1) >= DEPTH);
  end

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  p_bad_access_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && beyond_c |=> rsp_valid && rsp_err);

  p_err_zero_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == 32'h0);

  p_rsvd_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'b11 |=> rsp_err);

  p_byte_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_size == 2'b00 |=> rsp_rdata[31:8] == 24'h0);

  p_half_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_size == 2'b01 |=> rsp_rdata[31:16] == 16'h0);

  p_store_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> rsp_rdata == 32'h0);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r9: assert (!rsp_valid && !rsp_err && rsp_rdata == 32'h0);
    end
  end
endmodule

bind lemp_mem_port lemp_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/lemp_mem_port_test.sv
module lemp_mem_port_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int AW     = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;

  int applied = 0;
  int fails   = 0;
  bit done    = 0;
  logic [7:0] model [DEPTH];

  always #(PERIOD/2) clk = ~clk;

  lemp_mem_port #(.DEPTH(DEPTH)) uut (.*);

  function automatic int nb(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 0;
  endfunction

  function automatic bit is_bad(input logic [1:0] s, input int a);
    return (nb(s) == 0) || (a + nb(s) > DEPTH);
  endfunction

  function automatic logic [31:0] model_load(input logic [1:0] s, input int a);
    logic [31:0] v = 32'h0;
    for (int k = 0; k < nb(s); k++) v[8*k +: 8] = model[a + k];
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input bit wr, input logic [1:0] s, input int a,
                    input logic [31:0] wd, input string req);
    bit          bad = is_bad(s, a);
    logic [31:0] exp = (wr || bad) ? 32'h0 : model_load(s, a);
    req_valid = 1'b1; req_write = wr; req_size = s;
    req_addr = AW'(a); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R1 valid"}, {31'h0, rsp_valid}, 32'h1);
    check({req, " R7 err"}, {31'h0, rsp_err}, {31'h0, bad});
    check({req, " data"}, rsp_rdata, exp);
    if (wr && !bad)
      for (int k = 0; k < nb(s); k++) model[a + k] = wd[8*k +: 8];
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_size = 2'b00; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {31'h0, rsp_valid}, 32'h0);
    check("R9 reset err", {31'h0, rsp_err}, 32'h0);
    check("R9 reset data", rsp_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle no valid", {31'h0, rsp_valid}, 32'h0);

    // fill the array with four-byte stores
    for (int a = 0; a < DEPTH; a += 4) op(1'b1, 2'b10, a, $urandom, "R8 fill");

    // little-endian patterns, R2 and R4
    op(1'b1, 2'b00, 6, 32'h0B, "R2 byte");
    op(1'b1, 2'b00, 7, 32'h23, "R2 byte");
    op(1'b0, 2'b01, 6, 0, "R2 half at 6");
    check("R2 half 0x230B", model_load(2'b01, 6), 32'h0000230B);
    op(1'b1, 2'b00, 1, 32'h31, "R4 byte");
    op(1'b1, 2'b00, 2, 32'hCB, "R4 byte");
    op(1'b0, 2'b01, 1, 0, "R4 odd half");
    op(1'b1, 2'b10, 10, 32'h7AFE0636, "R4 quad store");
    op(1'b0, 2'b00, 10, 0, "R2 low byte at base");
    op(1'b0, 2'b00, 13, 0, "R2 high byte at base+3");
    op(1'b0, 2'b10, 10, 0, "R4 quad load");
    op(1'b0, 2'b10, 9, 0, "R4 shifted quad");

    // neighbours untouched, R6
    op(1'b1, 2'b10, 20, 32'hA1B2C3D4, "R6 setup");
    op(1'b1, 2'b00, 21, 32'hFFFFFF41, "R6 byte store");
    op(1'b0, 2'b10, 20, 0, "R6 neighbours");
    op(1'b1, 2'b01, 31, 32'hDEAD5A5A, "R6 half store");
    op(1'b0, 2'b10, 29, 0, "R6 around half");
    op(1'b0, 2'b10, 31, 0, "R6 after half");

    // zero extension, R5
    op(1'b0, 2'b00, 13, 0, "R5 byte zext");
    op(1'b0, 2'b01, 11, 0, "R5 half zext");

    // top of array, R7 and R3
    op(1'b0, 2'b10, DEPTH - 4, 0, "R7 quad fits");
    op(1'b1, 2'b10, DEPTH - 3, 32'h11223344, "R7 quad over");
    op(1'b1, 2'b01, DEPTH - 1, 32'h5566, "R7 half over");
    op(1'b0, 2'b00, DEPTH - 1, 0, "R7 last byte");
    op(1'b1, 2'b11, 4, 32'hFFFFFFFF, "R3 reserved store");
    op(1'b0, 2'b11, 4, 0, "R3 reserved load");
    op(1'b0, 2'b10, 4, 0, "R3 no write");
    op(1'b0, 2'b10, DEPTH - 4, 0, "R7 no write");

    // back-to-back random mix
    for (int n = 0; n < 600; n++) begin
      logic [1:0] s = 2'($urandom_range(0, 3));
      int a = $urandom_range(0, DEPTH - 1);
      if ($urandom_range(0, 9) != 0 && s == 2'b11) s = 2'b10;
      op(1'($urandom_range(0, 1)), s, a, $urandom, "R2 random");
    end

    @(negedge clk);
    check("R1 valid drops", {31'h0, rsp_valid}, 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule